// File: doc/BRIEF.md
# Framed Serial PCM Timeslot Port

This block moves one PCM word each way per frame over a synchronous serial link. An active-low frame strobe marks a timeslot of eight bit clocks. The port drives the outgoing word MSB first on a three-state data line. On the same clocks it collects the incoming PCM word and an 8-bit control word from two separate serial inputs. Outgoing bits change on rising clock edges and incoming bits are taken on falling edges, so each input bit is captured in the middle of its bit period.

A two-bit address code sampled with the strobe picks the purpose of the slot. For a negative or ground level, the slot carries PCM in both directions, and the control bits are handed to the primary control register. For the high level, PCM transfer is suppressed and the control bits are handed to the secondary control register. A system normally runs a PCM slot early in the frame and can add a second, high-address slot later in the same frame to update the secondary register. Completed words are presented in parallel with one-cycle load pulses. A slot whose strobe ends early is dropped.

Top module: `pcm_slot_port`

## Requirements
- R1: After synchronous reset, `pcm_out_en`, `pcm_out_ser`, `rx_word`, `ctl_word` and all pulse outputs are 0.
- R2: A slot starts on the first rising edge at which `frame_n` is sampled low while the port is idle and re-armed. With an address code of 00 (negative level) or 01 (ground), `pcm_out_en` goes high at that edge and `pcm_out_ser` shows bit 7 of `tx_word` as sampled at that edge.
- R3: The next seven rising edges put bits 6 down to 0 on `pcm_out_ser`. `pcm_out_en` is high for exactly eight cycles in a full slot and never for more than eight in a row.
- R4: Serial inputs are shifted in on the eight falling edges after the start edge, MSB first, so the first bit taken becomes bit 7 of the word.
- R5: For codes 00 and 01, the rising edge after the eighth captured bit updates `rx_word` and `ctl_word` and pulses `rx_word_vld` and `ctl_load_pri` for one cycle.
- R6: For code 10 (high level), `pcm_out_en` stays low and `rx_word` and `rx_word_vld` are unaffected. At the same completion edge, `ctl_word` is updated and `ctl_load_sec` pulses instead of `ctl_load_pri`.
- R7: If `frame_n` is sampled high before the eighth bit has been captured, the slot is aborted. `pcm_out_en` drops at that edge, no pulse is issued and no output word changes.
- R8: After a completed slot, a strobe still held low starts no new slot until it has been sampled high at least once.
- R9: Code 11 is reserved: such a slot drives nothing, issues no pulse and changes no word.
- R10: The address code and `tx_word` are sampled only at the start edge; changes to them during the slot have no effect on that slot.
- R11: `ctl_load_pri` and `ctl_load_sec` are never high together, and `rx_word_vld` is high only with `ctl_load_pri`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame/slot strobe |
| addr_lvl | input | 2 | Slot address code: 00 negative, 01 ground, 10 high, 11 reserved |
| pcm_in_ser | input | 1 | Serial PCM input |
| ctl_in_ser | input | 1 | Serial control input |
| tx_word | input | W | PCM word to send |
| pcm_out_ser | output | 1 | Serial PCM output data |
| pcm_out_en | output | 1 | Output enable for the three-state data driver |
| rx_word | output | W | Last PCM word received |
| rx_word_vld | output | 1 | One-cycle pulse when `rx_word` updates |
| ctl_word | output | W | Last control word received |
| ctl_load_pri | output | 1 | Load pulse for the primary control register |
| ctl_load_sec | output | 1 | Load pulse for the secondary control register |

## Verification
The properties assume that `frame_n` and `addr_lvl` change only away from rising edges and the serial inputs only away from falling edges, so every sample sees a settled level. They also assume that `tx_word` is valid at the edge where a slot starts. The stimulus drives strobe, address and transmit word just after falling edges and the serial inputs just after rising edges. It also flips the address and transmit word in the middle of a slot to show that only the start-edge values count. Slots with early strobe release, a strobe held long, and the reserved code are mixed with full slots in both address classes.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  typedef enum logic [1:0] {
    LVL_NEG  = 2'b00,
    LVL_GND  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSV  = 2'b11
  } addr_lvl_t;

  // Slot carries PCM traffic in both directions
  function automatic logic lvl_is_pcm(input logic [1:0] code);
    return (code == LVL_NEG) || (code == LVL_GND);
  endfunction

  // Slot carries a control word at all
  function automatic logic lvl_has_ctl(input logic [1:0] code);
    return code != LVL_RSV;
  endfunction

endpackage

// File: rtl/pcm_slot_seq.sv
// Slot sequencer: samples the strobe on rising edges, tracks bit position.
module pcm_slot_seq #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_n,
  input  logic [1:0]    addr_lvl,
  output logic          act,
  output logic [IW-1:0] idx,
  output logic [1:0]    mode,
  output logic          start_now,
  output logic          step_now,
  output logic          last_now,
  output logic          abort_now
);

  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  logic rearm_wait;

  always_comb begin
    start_now = !act && !frame_n && !rearm_wait;
    last_now  = act && (idx == LAST_IDX);
    abort_now = act && !last_now && frame_n;
    step_now  = act && !last_now && !frame_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act        <= 1'b0;
      idx        <= '0;
      mode       <= 2'b00;
      rearm_wait <= 1'b0;
    end else begin
      act <= start_now || step_now;
      if (start_now) begin
        idx  <= '0;
        mode <= addr_lvl;
      end else if (step_now) begin
        idx <= idx + 1'b1;
      end
      if (frame_n)
        rearm_wait <= 1'b0;
      else if (last_now)
        rearm_wait <= 1'b1;
    end
  end

endmodule

// File: rtl/pcm_tx_shift.sv
// Outgoing shifter: MSB first, one bit per rising edge.
module pcm_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  input  logic         stop,
  output logic         ser,
  output logic         oe
);

  logic [W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ser  <= 1'b0;
      oe   <= 1'b0;
    end else if (load) begin
      ser  <= word[W-1];
      pend <= word << 1;
      oe   <= 1'b1;
    end else if (stop) begin
      ser  <= 1'b0;
      oe   <= 1'b0;
    end else if (shift && oe) begin
      ser  <= pend[W-1];
      pend <= pend << 1;
    end
  end

endmodule

// File: rtl/pcm_rx_deser.sv
// Incoming deserializer: samples on falling edges, MSB first.
module pcm_rx_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ser,
  output logic [W-1:0] word
);

  always_ff @(negedge clk) begin
    if (rst)
      word <= '0;
    else if (en)
      word <= {word[W-2:0], ser};
  end

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_n,
  input  logic [1:0]   addr_lvl,
  input  logic         pcm_in_ser,
  input  logic         ctl_in_ser,
  input  logic [W-1:0] tx_word,
  output logic         pcm_out_ser,
  output logic         pcm_out_en,
  output logic [W-1:0] rx_word,
  output logic         rx_word_vld,
  output logic [W-1:0] ctl_word,
  output logic         ctl_load_pri,
  output logic         ctl_load_sec
);
  import pcm_slot_pkg::*;

  localparam int IW = (W > 2) ? $clog2(W) : 1;
  localparam int NLANE = 2;   // lane 0: PCM, lane 1: control

  logic          act, start_now, step_now, last_now, abort_now;
  logic [IW-1:0] idx;
  logic [1:0]    mode;

  pcm_slot_seq #(.W(W), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .frame_n(frame_n), .addr_lvl(addr_lvl),
    .act(act), .idx(idx), .mode(mode),
    .start_now(start_now), .step_now(step_now),
    .last_now(last_now), .abort_now(abort_now)
  );

  pcm_tx_shift #(.W(W)) u_tx (
    .clk(clk), .rst(rst),
    .load(start_now && lvl_is_pcm(addr_lvl)),
    .word(tx_word),
    .shift(step_now),
    .stop(last_now || abort_now),
    .ser(pcm_out_ser),
    .oe(pcm_out_en)
  );

  logic [NLANE-1:0] lane_ser, lane_en;
  logic [W-1:0]     lane_word [NLANE];

  assign lane_ser = {ctl_in_ser, pcm_in_ser};
  assign lane_en  = {act && lvl_has_ctl(mode), act && lvl_is_pcm(mode)};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    pcm_rx_deser #(.W(W)) u_rx (
      .clk(clk), .rst(rst), .en(lane_en[g]),
      .ser(lane_ser[g]), .word(lane_word[g])
    );
  end

  // Completion stage: parallel words and load pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word      <= '0;
      ctl_word     <= '0;
      rx_word_vld  <= 1'b0;
      ctl_load_pri <= 1'b0;
      ctl_load_sec <= 1'b0;
    end else begin
      rx_word_vld  <= last_now && lvl_is_pcm(mode);
      ctl_load_pri <= last_now && lvl_is_pcm(mode);
      ctl_load_sec <= last_now && (mode == LVL_HIGH);
      if (last_now && lvl_is_pcm(mode))
        rx_word <= lane_word[0];
      if (last_now && lvl_has_ctl(mode))
        ctl_word <= lane_word[1];
    end
  end

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         frame_n,
  input logic [W-1:0] tx_word,
  input logic         pcm_out_ser,
  input logic         pcm_out_en,
  input logic         rx_word_vld,
  input logic         ctl_load_pri,
  input logic         ctl_load_sec
);

  int unsigned oe_run;

  always_ff @(posedge clk) begin
    if (rst)
      oe_run <= 0;
    else if (pcm_out_en)
      oe_run <= oe_run + 1;
    else
      oe_run <= 0;
  end

  a_r2_start_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_out_en) |-> !$past(frame_n));

  a_r2_sign_first: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_out_en) |-> pcm_out_ser == $past(tx_word[W-1]));

  a_r3_enable_window: assert property (@(posedge clk) disable iff (rst)
    oe_run <= W);

  a_r5_pri_after_drive: assert property (@(posedge clk) disable iff (rst)
    ctl_load_pri |-> $past(pcm_out_en));

  a_r6_sec_no_drive: assert property (@(posedge clk) disable iff (rst)
    ctl_load_sec |-> !$past(pcm_out_en));

  a_r7_abort_on_high: assert property (@(posedge clk) disable iff (rst)
    ($fell(pcm_out_en) && !ctl_load_pri) |-> frame_n);

  a_r11_loads_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ctl_load_pri && ctl_load_sec));

  a_r11_vld_with_pri: assert property (@(posedge clk) disable iff (rst)
    rx_word_vld |-> ctl_load_pri);

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .tx_word(tx_word),
  .pcm_out_ser(pcm_out_ser), .pcm_out_en(pcm_out_en),
  .rx_word_vld(rx_word_vld), .ctl_load_pri(ctl_load_pri),
  .ctl_load_sec(ctl_load_sec)
);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_n = 1'b1;
  logic [1:0] addr_lvl = 2'b00;
  logic       pcm_in_ser = 1'b0;
  logic       ctl_in_ser = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       pcm_out_ser, pcm_out_en, rx_word_vld, ctl_load_pri, ctl_load_sec;
  logic [7:0] rx_word, ctl_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcm_slot_port #(.W(8)) uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .addr_lvl(addr_lvl),
    .pcm_in_ser(pcm_in_ser), .ctl_in_ser(ctl_in_ser), .tx_word(tx_word),
    .pcm_out_ser(pcm_out_ser), .pcm_out_en(pcm_out_en),
    .rx_word(rx_word), .rx_word_vld(rx_word_vld), .ctl_word(ctl_word),
    .ctl_load_pri(ctl_load_pri), .ctl_load_sec(ctl_load_sec)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m_busy = 0, m_hold = 0;
  int         m_pos = 0;
  logic [1:0] m_code = 0;
  logic [7:0] m_tx = 0;
  bit         pq[$];
  bit         cq[$];
  logic       e_oe = 0, e_ser = 0, e_vld = 0, e_pri = 0, e_sec = 0;
  logic [7:0] e_rx = 0, e_ctl = 0;
  int         n_oe = 0, n_pri = 0, n_sec = 0, n_vld = 0;

  function automatic logic [7:0] pack(input bit q[$]);
    logic [7:0] v = 0;
    foreach (q[k]) v = {v[6:0], q[k]};
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && m_busy) begin
      if (m_code <= 2'd1) pq.push_back(pcm_in_ser);
      if (m_code != 2'd3) cq.push_back(ctl_in_ser);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_hold = 0; m_pos = 0;
      e_oe = 0; e_ser = 0; e_vld = 0; e_pri = 0; e_sec = 0; e_rx = 0; e_ctl = 0;
    end else begin
      e_vld = 0; e_pri = 0; e_sec = 0;
      if (m_busy) begin
        if (m_pos == 7) begin
          m_busy = 0; e_oe = 0; e_ser = 0;
          m_hold = !frame_n;
          if (m_code <= 2'd1) begin
            e_pri = 1; e_vld = 1; e_rx = pack(pq); e_ctl = pack(cq);
          end else if (m_code == 2'd2) begin
            e_sec = 1; e_ctl = pack(cq);
          end
        end else if (frame_n) begin
          m_busy = 0; e_oe = 0; e_ser = 0;
        end else begin
          m_pos++;
          if (e_oe) e_ser = m_tx[7 - m_pos];
        end
      end else if (frame_n) begin
        m_hold = 0;
      end else if (!m_hold) begin
        m_busy = 1; m_pos = 0; m_code = addr_lvl; m_tx = tx_word;
        pq.delete(); cq.delete();
        if (addr_lvl <= 2'd1) begin
          e_oe = 1; e_ser = tx_word[7];
        end
      end
    end
    #1;
    if (!rst) begin
      check("R2", "enable", pcm_out_en, e_oe);
      check("R3", "data", pcm_out_ser, e_ser);
      check("R5", "pri load", ctl_load_pri, e_pri);
      check("R5", "valid", rx_word_vld, e_vld);
      check("R6", "sec load", ctl_load_sec, e_sec);
      check("R4", "rx word", rx_word, e_rx);
      check("R4", "ctl word", ctl_word, e_ctl);
      check("R11", "exclusive loads", ctl_load_pri & ctl_load_sec, 0);
      n_oe  += pcm_out_en;
      n_pri += ctl_load_pri;
      n_sec += ctl_load_sec;
      n_vld += rx_word_vld;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_slot(input logic [1:0] code, input logic [7:0] tx,
                          input logic [7:0] pin, input logic [7:0] cin,
                          input int nlow, input bit flip);
    n_oe = 0; n_pri = 0; n_sec = 0; n_vld = 0;
    @(negedge clk); #1;
    frame_n = 0; addr_lvl = code; tx_word = tx;
    for (int i = 0; i < nlow; i++) begin
      @(posedge clk); #1;
      if (i < 8) begin
        pcm_in_ser = pin[7 - i];
        ctl_in_ser = cin[7 - i];
      end else begin
        pcm_in_ser = ~pcm_in_ser;
        ctl_in_ser = ~ctl_in_ser;
      end
      @(negedge clk); #1;
      if (i == nlow - 1) frame_n = 1;
      if (flip && i == 2) begin
        addr_lvl = ~code;
        tx_word  = ~tx;
      end
    end
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset enable", pcm_out_en, 0);
    check("R1", "reset data", pcm_out_ser, 0);
    check("R1", "reset words", {rx_word, ctl_word}, 0);
    check("R1", "reset pulses", {rx_word_vld, ctl_load_pri, ctl_load_sec}, 0);
    rst = 0;
    idle(3);

    // R2 R3 R4 R5: full PCM slots on both PCM address levels
    run_slot(2'b00, 8'hA5, 8'h3C, 8'h81, 8, 0);
    check("R3", "enable cycles", n_oe, 8);
    check("R5", "pri pulses", n_pri, 1);
    check("R5", "valid pulses", n_vld, 1);
    check("R4", "rx word", rx_word, 8'h3C);
    check("R4", "ctl word", ctl_word, 8'h81);
    run_slot(2'b01, 8'h5A, 8'hF0, 8'h7E, 8, 0);
    check("R4", "rx word gnd", rx_word, 8'hF0);
    check("R5", "pri pulses gnd", n_pri, 1);
    run_slot(2'b00, 8'hFF, 8'h00, 8'hFF, 8, 0);
    run_slot(2'b01, 8'h00, 8'hFF, 8'h00, 8, 0);

    // R6: secondary slot in the same frame keeps the PCM word
    run_slot(2'b00, 8'h96, 8'h69, 8'h11, 8, 0);
    run_slot(2'b10, 8'hC3, 8'h12, 8'hB4, 8, 0);
    check("R6", "no drive", n_oe, 0);
    check("R6", "sec pulses", n_sec, 1);
    check("R6", "no pri", n_pri, 0);
    check("R6", "rx kept", rx_word, 8'h69);
    check("R6", "ctl word", ctl_word, 8'hB4);

    // R7: early strobe release
    run_slot(2'b00, 8'h3F, 8'hAA, 8'h55, 3, 0);
    check("R7", "abort enable cycles", n_oe, 3);
    check("R7", "abort pulses", n_pri + n_sec + n_vld, 0);
    check("R7", "abort rx kept", rx_word, 8'h69);
    run_slot(2'b10, 8'h3F, 8'hAA, 8'h55, 7, 0);
    check("R7", "abort sec pulses", n_sec, 0);
    check("R7", "abort ctl kept", ctl_word, 8'hB4);

    // R8: strobe held low beyond the slot
    run_slot(2'b01, 8'hE7, 8'h24, 8'h42, 14, 0);
    check("R8", "enable cycles held", n_oe, 8);
    check("R8", "one load held", n_pri, 1);
    check("R8", "rx held", rx_word, 8'h24);
    run_slot(2'b00, 8'h18, 8'hDB, 8'hBD, 8, 0);
    check("R8", "rearm after high", rx_word, 8'hDB);

    // R9: reserved code
    run_slot(2'b11, 8'hAB, 8'hCD, 8'hEF, 8, 0);
    check("R9", "reserved drive", n_oe, 0);
    check("R9", "reserved pulses", n_pri + n_sec + n_vld, 0);
    check("R9", "reserved words", {rx_word, ctl_word}, {8'hDB, 8'hBD});

    // R10: address and transmit word changed mid-slot
    run_slot(2'b01, 8'hC6, 8'h5B, 8'hA4, 8, 1);
    check("R10", "flip enable cycles", n_oe, 8);
    check("R10", "flip pri", n_pri, 1);
    check("R10", "flip sec", n_sec, 0);
    run_slot(2'b10, 8'h00, 8'h77, 8'h3D, 8, 1);
    check("R10", "flip sec slot", n_sec, 1);
    check("R10", "flip no drive", n_oe, 0);
    check("R10", "flip ctl", ctl_word, 8'h3D);

    // R1: reset mid-run clears outputs
    @(negedge clk); #1; rst = 1;
    @(negedge clk); @(negedge clk); #1;
    check("R1", "re-reset words", {rx_word, ctl_word}, 0);
    rst = 0;
    idle(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule